// File: doc/BRIEF.md
# Half-Bridge Input Interlock Conditioner

This block sits between the control logic and the two gate drivers of a half-bridge. It takes a high-side command, a low-side command, an active-low shutdown and one supply-good flag per side, all asynchronous to the block clock. From these it produces the two gate enable outputs and guarantees that both are never on together.

Every input first passes a two-stage synchroniser. On the high-side path a pulse stretcher gives every output level a minimum duration, and a fixed transmit latency follows it. The low-side path has no stretcher. It carries a matching delay equal to the stretcher register plus the transmit latency, so a command edge on either side reaches its gate after the same number of cycles. The final output register applies shutdown, supply qualification and the both-high interlock. A stretched or delayed pulse therefore cannot get past any of them.

Delays are given in clock cycles. The minimum high-side level time is derived from a duration and a clock period in picoseconds, rounded up.

Top module: `hb_gate_cond`

## Requirements
- R1: While the synchronised shutdown input (`shdn_n`) is 0, both gate outputs are 0 and command changes have no effect. A 0 sampled on `shdn_n` at a clock edge forces both outputs off two edges later.
- R2: With shutdown released and both supplies good, `hi_cmd`=1 with `lo_cmd`=0 drives only `hi_gate` to 1. `lo_cmd`=1 with `hi_cmd`=0 drives only `lo_gate` to 1.
- R3: When the two commands reaching the output stage are both 1, both outputs are 0 until one of them returns to 0. `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R4: On the high-side path, every level (on or off) lasts at least `STRETCH_CYC` cycles. A command pulse or gap shorter than that yields an output level exactly `STRETCH_CYC` cycles long. Longer pulses keep their width.
- R5: The low-side path has no minimum-width stage: a one-cycle `lo_cmd` pulse yields a one-cycle `lo_gate` pulse.
- R6: The latency from a command edge sampled at a clock edge to the matching output edge is `XMIT_LAT`+3 edges on both channels, for turn-on and turn-off alike. With defaults this is 5 edges (100 ns at 50 MHz), so the channel mismatch is zero cycles.
- R7: Each output is 1 only while its own supply-good flag is 1. A 0 sampled on a flag turns that side's output off two edges later and leaves the other side unchanged.
- R8: Synchronous active-high reset drives both outputs to 0 and clears the synchronisers, stretcher and delay lines. No pulse captured before reset appears afterwards.
- R9: Shutdown, supply qualification and interlock act after the stretch and delay stages. A stretched high-side pulse is cut off by a shutdown that arrives during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | High-side command, asynchronous |
| lo_cmd | input | 1 | Low-side command, asynchronous |
| shdn_n | input | 1 | Shutdown, active low, asynchronous |
| hi_supply_ok | input | 1 | High-side supply-good flag |
| lo_supply_ok | input | 1 | Low-side supply-good flag |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
The assertions assume that the inputs, although nominally asynchronous, settle well away from the sampling edge. Under that assumption the synchroniser outputs are clean delayed copies of the inputs. The bench changes every input only just after a falling clock edge, so each value is captured at one known rising edge. This makes the reference model's edge counting exact for latency, stretching and forcing. The random sweep also keeps to this timing and mixes rare shutdown and supply drops with frequent command toggles. That mix produces both-high overlaps and sub-minimum pulses.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Register count of the high-side stretcher stage
    localparam int STRETCH_LAT = 1;

    // Raw inputs, carried as one bundle through the synchroniser
    typedef struct packed {
        logic sd_n;
        logic hi;
        logic lo;
        logic hok;
        logic lok;
    } hb_in_t;

    localparam int IN_W = $bits(hb_in_t);

    // Output stage decision
    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HI  = 2'd1,
        DRV_LO  = 2'd2
    } drv_e;

    // Round a duration up to whole clock periods (at least one)
    function automatic int cycles_for(input int span_ps, input int period_ps);
        int c;
        c = (span_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Interlock decision on the aligned commands
    function automatic drv_e decide(input logic sd_n, input logic hi, input logic lo);
        drv_e d;
        if (!sd_n)
            d = DRV_OFF;
        else if (hi && !lo)
            d = DRV_HI;
        else if (lo && !hi)
            d = DRV_LO;
        else
            d = DRV_OFF;
        return d;
    endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/hbg_stretch.sv
module hbg_stretch #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    if (MIN_CYC <= 1) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= d;
        end
    end else begin : g_hold
        localparam int CW = $clog2(MIN_CYC);
        logic [CW-1:0] hold;

        always_ff @(posedge clk) begin
            if (rst) begin
                q    <= 1'b0;
                hold <= '0;
            end else if (hold != '0) begin
                hold <= hold - 1'b1;
            end else if (d != q) begin
                q    <= d;
                hold <= CW'(MIN_CYC - 1);
            end
        end
    end
endmodule

// File: rtl/hbg_dline.sv
module hbg_dline #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    if (DEPTH == 0) begin : g_none
        assign q = d;
    end else begin : g_chain
        logic [DEPTH-1:0] taps;
        always_ff @(posedge clk) begin
            if (rst) taps <= '0;
            else     taps <= {taps[DEPTH-2 >= 0 ? DEPTH-2 : 0 : 0], d};
        end
        assign q = taps[DEPTH-1];
    end
endmodule

// File: rtl/hbg_outstage.sv
module hbg_outstage
    import hbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sd_n,
    input  logic hok,
    input  logic lok,
    input  logic hi,
    input  logic lo,
    output logic hi_gate,
    output logic lo_gate
);
    drv_e drv;

    always_comb drv = decide(sd_n, hi, lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_gate <= 1'b0;
            lo_gate <= 1'b0;
        end else begin
            hi_gate <= (drv == DRV_HI) && hok;
            lo_gate <= (drv == DRV_LO) && lok;
        end
    end
endmodule

// File: rtl/hb_gate_cond.sv
module hb_gate_cond
    import hbg_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int MIN_PULSE_PS  = 50000,
    parameter int STRETCH_CYC   = hbg_pkg::cycles_for(MIN_PULSE_PS, CLK_PERIOD_PS),
    parameter int XMIT_LAT      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic shdn_n,
    input  logic hi_supply_ok,
    input  logic lo_supply_ok,
    output logic hi_gate,
    output logic lo_gate
);
    localparam int LO_DLY = STRETCH_LAT + XMIT_LAT;

    hb_in_t     raw;
    hb_in_t     syn;
    logic [IN_W-1:0] syn_vec;
    logic       sd_s, hok_s, lok_s;
    logic       hi_st, hi_al, lo_al;

    always_comb begin
        raw.sd_n = shdn_n;
        raw.hi   = hi_cmd;
        raw.lo   = lo_cmd;
        raw.hok  = hi_supply_ok;
        raw.lok  = lo_supply_ok;
    end

    hbg_sync #(.W(IN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_vec)
    );

    assign syn   = hb_in_t'(syn_vec);
    assign sd_s  = syn.sd_n;
    assign hok_s = syn.hok;
    assign lok_s = syn.lok;

    hbg_stretch #(.MIN_CYC(STRETCH_CYC)) u_stretch (
        .clk (clk),
        .rst (rst),
        .d   (syn.hi),
        .q   (hi_st)
    );

    hbg_dline #(.DEPTH(XMIT_LAT)) u_hi_xmit (
        .clk (clk),
        .rst (rst),
        .d   (hi_st),
        .q   (hi_al)
    );

    hbg_dline #(.DEPTH(LO_DLY)) u_lo_match (
        .clk (clk),
        .rst (rst),
        .d   (syn.lo),
        .q   (lo_al)
    );

    hbg_outstage u_out (
        .clk     (clk),
        .rst     (rst),
        .sd_n    (sd_s),
        .hok     (hok_s),
        .lok     (lok_s),
        .hi      (hi_al),
        .lo      (lo_al),
        .hi_gate (hi_gate),
        .lo_gate (lo_gate)
    );
endmodule

// File: rtl/hbg_checks.sv
module hbg_checks #(
    parameter int MIN_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic hi_gate,
    input logic lo_gate,
    input logic sd_s,
    input logic hok_s,
    input logic lok_s,
    input logic hi_st
);
    localparam int RW = $clog2(MIN_CYC + 1);

    logic [RW-1:0] run;
    logic          prev_st;
    logic          chg;

    assign chg = (hi_st != prev_st);

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= RW'(MIN_CYC);
            prev_st <= 1'b0;
        end else begin
            prev_st <= hi_st;
            if (chg)
                run <= RW'(1);
            else if (run < RW'(MIN_CYC))
                run <= run + 1'b1;
        end
    end

    // R3
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate && lo_gate));

    // R1
    shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sd_s |=> (!hi_gate && !lo_gate));

    // R7
    hi_supply_chk: assert property (@(posedge clk) disable iff (rst)
        !hok_s |=> !hi_gate);

    // R7
    lo_supply_chk: assert property (@(posedge clk) disable iff (rst)
        !lok_s |=> !lo_gate);

    // R4
    min_level_chk: assert property (@(posedge clk) disable iff (rst)
        chg |-> (run >= RW'(MIN_CYC - 1)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!hi_gate && !lo_gate));
endmodule

bind hb_gate_cond hbg_checks #(.MIN_CYC(STRETCH_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hi_gate (hi_gate),
    .lo_gate (lo_gate),
    .sd_s    (sd_s),
    .hok_s   (hok_s),
    .lok_s   (lok_s),
    .hi_st   (hi_st)
);

// File: tb/test_hb_gate_cond.sv
`timescale 1ns/1ps
module test_hb_gate_cond;
    localparam int W    = 3;
    localparam int XMIT = 2;
    localparam int LAT  = XMIT + 3;
    localparam int HD   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, shdn_n = 1'b0;
    logic hi_supply_ok = 1'b0, lo_supply_ok = 1'b0;
    logic hi_gate, lo_gate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hb_gate_cond #(
        .CLK_PERIOD_PS(20000), .MIN_PULSE_PS(50000), .XMIT_LAT(XMIT)
    ) i_hb_gate_cond (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .shdn_n(shdn_n),
        .hi_supply_ok(hi_supply_ok), .lo_supply_ok(lo_supply_ok),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    // Reference model: histories of the values sampled at each rising edge
    logic hh [HD], lh [HD], sh [HD], hkh [HD], lkh [HD], sth [HD];
    logic st_m;
    int   cyc, last_chg;
    logic exp_hi, exp_lo;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            for (int i = 0; i < HD; i++) begin
                hh[i] = 0; lh[i] = 0; sh[i] = 0; hkh[i] = 0; lkh[i] = 0; sth[i] = 0;
            end
            st_m = 0;
            last_chg = cyc - 1000;
            exp_hi = 0;
            exp_lo = 0;
        end else begin
            for (int i = HD - 1; i > 0; i--) begin
                hh[i] = hh[i-1]; lh[i] = lh[i-1]; sh[i] = sh[i-1];
                hkh[i] = hkh[i-1]; lkh[i] = lkh[i-1]; sth[i] = sth[i-1];
            end
            hh[0] = hi_cmd; lh[0] = lo_cmd; sh[0] = shdn_n;
            hkh[0] = hi_supply_ok; lkh[0] = lo_supply_ok;
            if (hh[2] != st_m && (cyc - last_chg) >= W) begin
                st_m = hh[2];
                last_chg = cyc;
            end
            sth[0] = st_m;
            exp_hi = sh[2] && hkh[2] && sth[XMIT+1] && !lh[XMIT+3];
            exp_lo = sh[2] && lkh[2] && lh[XMIT+3] && !sth[XMIT+1];
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance one cycle and compare against the model
    task automatic tick(input string tag);
        @(negedge clk);
        check(tag, hi_gate, exp_hi, "hi_gate vs model");
        check(tag, lo_gate, exp_lo, "lo_gate vs model");
        check("R3", hi_gate && lo_gate, 1'b0, "both gates on");
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic idle_on();
        hi_cmd = 0; lo_cmd = 0; shdn_n = 1; hi_supply_ok = 1; lo_supply_ok = 1;
    endtask

    task automatic t_reset();
        rst = 1;
        idle_on();
        hi_cmd = 1;
        ticks("R8", 3);
        check("R8", hi_gate, 1'b0, "hi_gate in reset");
        check("R8", lo_gate, 1'b0, "lo_gate in reset");
        rst = 0;
        hi_cmd = 0;
        ticks("R8", 10);
    endtask

    task automatic t_latency();
        int n;
        idle_on();
        ticks("R6", 10);
        hi_cmd = 1;
        n = 0;
        do begin tick("R6"); n++; end while (!hi_gate && n < 20);
        check_int("R6", n, LAT + 1, "hi turn-on ticks");
        hi_cmd = 0;
        n = 0;
        do begin tick("R6"); n++; end while (hi_gate && n < 20);
        check_int("R6", n, LAT + 1, "hi turn-off ticks");
        ticks("R6", 6);
        lo_cmd = 1;
        n = 0;
        do begin tick("R6"); n++; end while (!lo_gate && n < 20);
        check_int("R6", n, LAT + 1, "lo turn-on ticks");
        lo_cmd = 0;
        n = 0;
        do begin tick("R6"); n++; end while (lo_gate && n < 20);
        check_int("R6", n, LAT + 1, "lo turn-off ticks");
        ticks("R6", 6);
    endtask

    task automatic t_exclusive();
        idle_on();
        hi_cmd = 1;
        ticks("R2", 10);
        check("R2", hi_gate, 1'b1, "hi only -> hi_gate");
        check("R2", lo_gate, 1'b0, "hi only -> lo_gate");
        hi_cmd = 0; lo_cmd = 1;
        ticks("R2", 10);
        check("R2", lo_gate, 1'b1, "lo only -> lo_gate");
        check("R2", hi_gate, 1'b0, "lo only -> hi_gate");
        lo_cmd = 0;
        ticks("R2", 8);
    endtask

    task automatic t_both();
        idle_on();
        hi_cmd = 1;
        ticks("R3", 8);
        lo_cmd = 1;
        ticks("R3", 8);
        check("R3", hi_gate, 1'b0, "both high -> hi_gate");
        check("R3", lo_gate, 1'b0, "both high -> lo_gate");
        hi_cmd = 0;
        ticks("R3", 8);
        check("R3", lo_gate, 1'b1, "hi released -> lo_gate");
        lo_cmd = 0;
        ticks("R3", 8);
    endtask

    task automatic t_shutdown();
        int n;
        idle_on();
        hi_cmd = 1;
        ticks("R1", 8);
        shdn_n = 0;
        ticks("R1", 2);
        check("R1", hi_gate, 1'b1, "still on before shutdown lands");
        tick("R1");
        check("R1", hi_gate, 1'b0, "off two edges after shutdown");
        n = 0;
        for (int i = 0; i < 12; i++) begin
            hi_cmd = i[0]; lo_cmd = i[1];
            tick("R1");
            n += hi_gate + lo_gate;
        end
        check_int("R1", n, 0, "gate cycles during shutdown");
        hi_cmd = 0; lo_cmd = 0; shdn_n = 1;
        ticks("R1", 8);
    endtask

    task automatic t_supply();
        idle_on();
        hi_cmd = 1;
        ticks("R7", 8);
        hi_supply_ok = 0;
        ticks("R7", 3);
        check("R7", hi_gate, 1'b0, "hi off after hi supply drop");
        hi_supply_ok = 1;
        ticks("R7", 4);
        check("R7", hi_gate, 1'b1, "hi back on");
        hi_cmd = 0; lo_cmd = 1;
        ticks("R7", 8);
        hi_supply_ok = 0;
        ticks("R7", 4);
        check("R7", lo_gate, 1'b1, "lo unaffected by hi supply");
        lo_supply_ok = 0;
        ticks("R7", 3);
        check("R7", lo_gate, 1'b0, "lo off after lo supply drop");
        idle_on();
        ticks("R7", 8);
    endtask

    task automatic t_stretch();
        int n;
        idle_on();
        ticks("R4", 6);
        hi_cmd = 1; tick("R4"); hi_cmd = 0;
        n = 0;
        for (int i = 0; i < 15; i++) begin tick("R4"); n += hi_gate; end
        check_int("R4", n, W, "1-cycle hi pulse width");
        hi_cmd = 1; ticks("R4", 5); hi_cmd = 0;
        n = 0;
        for (int i = 0; i < 15; i++) begin tick("R4"); n += hi_gate; end
        check_int("R4", n, 5, "5-cycle hi pulse width");
        hi_cmd = 1; ticks("R4", 10);
        hi_cmd = 0; tick("R4"); hi_cmd = 1;
        n = 0;
        for (int i = 0; i < 12; i++) begin tick("R4"); n += !hi_gate; end
        check_int("R4", n, W, "1-cycle hi gap width");
        hi_cmd = 0;
        ticks("R4", 8);
    endtask

    task automatic t_lo_plain();
        int n;
        idle_on();
        ticks("R5", 6);
        lo_cmd = 1; tick("R5"); lo_cmd = 0;
        n = 0;
        for (int i = 0; i < 12; i++) begin tick("R5"); n += lo_gate; end
        check_int("R5", n, 1, "1-cycle lo pulse width");
    endtask

    task automatic t_cut();
        int n;
        idle_on();
        ticks("R9", 6);
        hi_cmd = 1; tick("R9"); hi_cmd = 0;
        ticks("R9", 2);
        shdn_n = 0;
        n = 0;
        for (int i = 0; i < 12; i++) begin tick("R9"); n += hi_gate; end
        check_int("R9", n, 0, "stretched pulse cut by shutdown");
        shdn_n = 1;
        ticks("R9", 6);
    endtask

    task automatic t_reset_mid();
        int n;
        idle_on();
        ticks("R8", 6);
        hi_cmd = 1; lo_cmd = 0; tick("R8"); hi_cmd = 0;
        tick("R8");
        rst = 1;
        tick("R8");
        rst = 0;
        n = 0;
        for (int i = 0; i < 12; i++) begin tick("R8"); n += hi_gate + lo_gate; end
        check_int("R8", n, 0, "stale pulse after reset");
    endtask

    task automatic t_sweep();
        logic [15:0] lfsr = 16'hACE1;
        idle_on();
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hi_cmd = lfsr[0];
            lo_cmd = lfsr[3] & lfsr[5];
            shdn_n = !(lfsr[7] & lfsr[9] & lfsr[11]);
            hi_supply_ok = !(lfsr[2] & lfsr[8] & lfsr[14] & lfsr[4]);
            lo_supply_ok = !(lfsr[1] & lfsr[6] & lfsr[12] & lfsr[10]);
            tick("R3");
        end
        idle_on();
        ticks("R3", 8);
    endtask

    initial begin
        cyc = 0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_exclusive();
        t_both();
        t_shutdown();
        t_supply();
        t_stretch();
        t_lo_plain();
        t_cut();
        t_reset_mid();
        t_sweep();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule